// File: doc/BRIEF.md
# SPI Switch-Input Monitor with Maskable Interrupt

The block watches a bank of digital switch inputs and reports them over a serial port of the SPI kind. When chip select falls, the input levels are frozen into a snapshot register. The snapshot is then shifted out most significant bit first, and the pending interrupt is cleared. During the same frame, bits arriving on the serial input are shifted in behind the snapshot. When chip select rises, the last word shifted in becomes the interrupt enable mask.

Between frames, a per-bit comparator checks the live inputs against the snapshot. An active-low interrupt is raised while any enabled input differs from its snapshot bit and the interrupt-enable pin is high. The interrupt output is modelled as open-drain: a level plus a drive enable that is only active when pulling low.

All serial pins and switch inputs pass through synchronizers into one system clock, which must run at least four times faster than the serial clock. The serial output is driven only while chip select is low. Several devices can be chained by feeding one serial output into the next serial input.

Top module: `spi_gpi_monitor`

## Requirements
- R1: After reset, `int_n` is 1, `int_oe` is 0 and every mask bit is 0, so no input change can raise the interrupt.
- R2: A falling `cs_n` captures the synchronized inputs into the snapshot. Input changes later in the frame do not alter the word read out.
- R3: After `cs_n` falls, `sdout` shows snapshot bit 15. Each rising `sclk` advances `sdout` to the next lower bit.
- R4: `sdin` is captured on the falling edge of `sclk` and shifted in at the next rising edge. A change of `sdin` between those two edges has no effect.
- R5: A rising `cs_n` loads the 16 most recently shifted-in bits into the mask. The first bit of those 16 goes to mask bit 15, and a mask bit of 1 enables that input. A change on an input whose mask bit is 0 leaves `int_n` at 1.
- R6: With `int_en` high, `int_n` is 0 and `int_oe` is 1 while any enabled input differs from its snapshot bit.
- R7: While `int_en` is low, `int_n` is 1 and `int_oe` is 0. When `int_en` returns high with the difference still present, the interrupt reappears.
- R8: A falling `cs_n` clears a pending interrupt by taking a fresh snapshot.
- R9: Shifting in an all-zero word acts as a soft reset: all inputs become masked and no change raises the interrupt.
- R10: `sdout_oe` is 0 whenever `cs_n` is high and 1 during a frame.
- R11: In a frame longer than 16 bits, `sdout` replays the `sdin` bits delayed by 16 clocks, so devices can be chained.
- R12: The interrupt follows the live comparison. When an enabled input returns to its snapshot value, `int_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | 16 | Asynchronous switch inputs |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in (mask word, or chained data) |
| int_en | input | 1 | Interrupt enable |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | Drive enable for sdout |
| int_n | output | 1 | Interrupt level, active low |
| int_oe | output | 1 | Open-drain pull-down enable for the interrupt |

## Verification
The bench changes inputs in the middle of a frame. A design that shifted out live inputs instead of the snapshot would return a corrupted word. It also flips `sdin` between the falling and rising edges of `sclk`. A design sampling on the wrong edge would load an inverted mask, which then shows up as an interrupt on an input that should be masked.

A 32-bit frame checks that the output replays the input delayed by 16 bits, which catches an off-by-one shift length. The remaining tests cover three further faults: an interrupt that latches instead of following the live comparison, an interrupt that stays set across a new snapshot, and an enable pin that fails to silence the output.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
  // Edge events of the synchronized serial pins, valid for one clock.
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_fall;
    logic sclk_rise;
  } spi_evt_t;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gpi_edge.sv
module gpi_edge
  import gpi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_s,
  input  logic     sclk_s,
  output spi_evt_t ev
);
  logic cs_d, sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign ev.cs_fall   = cs_d & ~cs_s;
  assign ev.cs_rise   = ~cs_d & cs_s;
  assign ev.sclk_fall = sclk_d & ~sclk_s;
  assign ev.sclk_rise = ~sclk_d & sclk_s;
endmodule

// File: rtl/gpi_serial.sv
module gpi_serial
  import gpi_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_s,
  input  logic         cs_s,
  input  logic         sdin_s,
  input  spi_evt_t     ev,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         sdout,
  output logic         sdout_oe
);
  logic [N-1:0] shreg;
  logic         sdin_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= '0;
      shreg     <= '0;
      mask      <= '0;
      sdin_hold <= 1'b0;
      sdout_oe  <= 1'b0;
    end else begin
      sdout_oe <= ~cs_s;
      if (ev.cs_fall) begin
        status <= in_s;
        shreg  <= in_s;
      end else if (!cs_s) begin
        if (ev.sclk_fall) sdin_hold <= sdin_s;
        if (ev.sclk_rise) shreg <= {shreg[N-2:0], sdin_hold};
      end
      if (ev.cs_rise) mask <= shreg;
    end
  end

  assign sdout = shreg[N-1];

  p_snapshot_r2: assert property (@(posedge clk) disable iff (rst)
    ev.cs_fall |=> (status == $past(in_s)));
  p_shift_in_r4: assert property (@(posedge clk) disable iff (rst)
    (ev.sclk_rise && !cs_s && !ev.cs_fall) |=> (shreg[0] == $past(sdin_hold)));
  p_mask_commit_r5: assert property (@(posedge clk) disable iff (rst)
    ev.cs_rise |=> (mask == $past(shreg)));
  p_hiz_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdout_oe);
endmodule

// File: rtl/gpi_irq.sv
module gpi_irq #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_s,
  input  logic [N-1:0] status,
  input  logic [N-1:0] mask,
  input  logic         int_en,
  input  logic         cs_fall,
  output logic         int_n,
  output logic         int_oe
);
  logic [N-1:0] diff;
  logic         hit;

  assign diff = (in_s ^ status) & mask;
  assign hit  = |diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n  <= 1'b1;
      int_oe <= 1'b0;
    end else if (cs_fall || !int_en) begin
      int_n  <= 1'b1;
      int_oe <= 1'b0;
    end else begin
      int_n  <= ~hit;
      int_oe <= hit;
    end
  end

  p_int_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> (int_n && !int_oe));
  p_int_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> int_n);
  p_all_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> int_n);
  p_int_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> $past(int_en));
endmodule

// File: rtl/spi_gpi_monitor.sv
module spi_gpi_monitor
  import gpi_pkg::*;
#(
  parameter int N_IN = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] sw_in,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdin,
  input  logic            int_en,
  output logic            sdout,
  output logic            sdout_oe,
  output logic            int_n,
  output logic            int_oe
);
  logic [N_IN-1:0] in_s, status, mask;
  logic [2:0]      pins_s;
  spi_evt_t        ev;

  gpi_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_in (
    .clk(clk), .rst(rst), .d(sw_in), .q(in_s));

  // bit 2 = chip select, bit 1 = serial clock (both idle high), bit 0 = data
  gpi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync_spi (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdin}), .q(pins_s));

  gpi_edge i_edge (
    .clk(clk), .rst(rst), .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .ev(ev));

  gpi_serial #(.N(N_IN)) i_serial (
    .clk(clk), .rst(rst), .in_s(in_s), .cs_s(pins_s[2]), .sdin_s(pins_s[0]),
    .ev(ev), .status(status), .mask(mask), .sdout(sdout), .sdout_oe(sdout_oe));

  gpi_irq #(.N(N_IN)) i_irq (
    .clk(clk), .rst(rst), .in_s(in_s), .status(status), .mask(mask),
    .int_en(int_en), .cs_fall(ev.cs_fall), .int_n(int_n), .int_oe(int_oe));
endmodule

// File: tb/test_spi_gpi_monitor.sv
module test_spi_gpi_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw_in = '0;
  logic        cs_n = 1'b1, sclk = 1'b1, sdin = 1'b0, int_en = 1'b1;
  logic        sdout, sdout_oe, int_n, int_oe;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_gpi_monitor i_spi_gpi_monitor (
    .clk(clk), .rst(rst), .sw_in(sw_in), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .int_en(int_en), .sdout(sdout), .sdout_oe(sdout_oe), .int_n(int_n), .int_oe(int_oe));

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Shifts nb bits; mosi sent from bit nb-1 down. miso collected in send order.
  task automatic frame(input int nb, input logic [63:0] mosi, input bit glitch,
                       input int mid_at, input logic [15:0] mid_val,
                       output logic [63:0] miso);
    miso = '0;
    cs_n = 1'b0;
    wclk(W);
    for (int i = 0; i < nb; i++) begin
      if (i == mid_at) sw_in = mid_val;
      sdin = mosi[nb-1-i];
      wclk(2);
      sclk = 1'b0;
      wclk(W);
      miso = {miso[62:0], sdout};
      if (glitch) sdin = ~mosi[nb-1-i];
      wclk(2);
      sclk = 1'b1;
      wclk(W);
    end
    cs_n = 1'b1;
    wclk(W);
  endtask

  task automatic t_reset;
    chk("R1 int_n", int_n, 1);
    chk("R1 int_oe", int_oe, 0);
    chk("R10 sdout_oe idle", sdout_oe, 0);
    sw_in = 16'hFFFF;
    wclk(W);
    chk("R1 all masked", int_n, 1);
  endtask

  task automatic t_hiz;
    sw_in = 16'h8001;
    cs_n = 1'b0;
    wclk(W);
    chk("R10 sdout_oe active", sdout_oe, 1);
    chk("R3 msb first", sdout, 1);
    cs_n = 1'b1;
    wclk(W);
    chk("R10 sdout_oe after frame", sdout_oe, 0);
  endtask

  task automatic t_read;
    logic [63:0] m;
    sw_in = 16'hA5C3;
    wclk(W);
    frame(16, 64'h0, 0, 5, 16'h0F0F, m);
    chk("R2 R3 snapshot readout", m[15:0], 16'hA5C3);
  endtask

  task automatic t_daisy;
    logic [63:0] m;
    sw_in = 16'h0000;
    wclk(W);
    frame(32, {32'h0, 16'h3C5A, 16'h0001}, 1, -1, 16'h0, m);
    chk("R11 chained data", m[15:0], 16'h3C5A);
    chk("R11 snapshot part", m[31:16], 16'h0000);
  endtask

  task automatic t_mask;
    sw_in = 16'h0002;
    wclk(W);
    chk("R5 R4 masked input quiet", int_n, 1);
    sw_in = 16'h0003;
    wclk(W);
    chk("R6 int_n", int_n, 0);
    chk("R6 int_oe", int_oe, 1);
  endtask

  task automatic t_follow;
    sw_in = 16'h0002;
    wclk(W);
    chk("R12 returns to snapshot", int_n, 1);
    sw_in = 16'h0003;
    wclk(W);
    chk("R12 reasserts", int_n, 0);
  endtask

  task automatic t_inten;
    int_en = 1'b0;
    wclk(W);
    chk("R7 int_n gated", int_n, 1);
    chk("R7 int_oe gated", int_oe, 0);
    int_en = 1'b1;
    wclk(W);
    chk("R7 reenabled", int_n, 0);
  endtask

  task automatic t_clear;
    logic [63:0] m;
    frame(16, 64'h0001, 0, -1, 16'h0, m);
    chk("R8 cleared by snapshot", int_n, 1);
    chk("R8 readout of live inputs", m[15:0], 16'h0003);
    sw_in = 16'h0002;
    wclk(W);
    chk("R8 R5 mask kept", int_n, 0);
  endtask

  task automatic t_swreset;
    logic [63:0] m;
    frame(16, 64'h0, 0, -1, 16'h0, m);
    chk("R9 cleared", int_n, 1);
    sw_in = 16'hFFFD;
    wclk(W);
    chk("R9 all masked", int_n, 1);
    chk("R9 int_oe", int_oe, 0);
  endtask

  initial begin
    wclk(4);
    rst = 1'b0;
    wclk(4);
    t_reset();
    t_hiz();
    t_read();
    t_daisy();
    t_mask();
    t_follow();
    t_inten();
    t_clear();
    t_swreset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule